// File: doc/BRIEF.md
# Column-Popcount Serial Multiplier

This block multiplies two unsigned P-bit operands without any adder tree. The product is formed weight by weight. Every weight column is a bag of single-bit elements: the AND terms whose indices sum to that weight, plus the carry bits handed forward by lower columns. A single counter walks through the bag one element per clock and tallies the ones. When a column is finished, the low bit of its tally becomes the matching product bit. Each higher tally bit k is filed as an extra element of the column k places further up.

A pulse on `start` while the block is idle captures both operands and clears the previous result. The block then sweeps the 2P columns from the least significant to the most significant. One cycle after the top column is committed, `done` pulses for one cycle. The product then stays frozen until the next accepted start.

Every column reserves min(r, L) carry slots, where L = clog2(P). The carry slots are scanned even when they hold zero, so the latency depends only on P and never on the operand values.

Top module: `colcount_mult`

## Requirements
- R1: While reset is asserted and after it is released, `product` reads 0 and `done` reads 0 until the first accepted start.
- R2: Columns are committed in ascending order r = 0 .. 2P-1. At the `done` pulse, `product` equals the unsigned product of the operands captured at the accepted start.
- R3: The tally is cleared at the start of each column and grows by one for each element that is 1. It never exceeds the number of elements scanned so far in that column.
- R4: Column r holds the terms A[j]&B[r-j] for every j with 0 <= j <= P-1 and 0 <= r-j <= P-1. It also holds bit k (k >= 1) of the tally of column r-k. Product bit r is bit 0 of column r's tally.
- R5: A tally bit whose destination column would be 2P or higher is always 0. Dropping it loses nothing, including for all-ones operands.
- R6: One element is scanned per clock. `done` rises exactly T clocks after the edge that accepts `start`, where T = sum over r of (number of AND terms in column r + min(r, clog2(P))), which is 106 for P = 8. `done` stays high for exactly one cycle.
- R7: A `start` pulse that arrives while a multiplication is running is ignored. The running result and its latency are unchanged.
- R8: While idle without `start`, `product` holds its value and `done` stays low, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to capture the operands and begin; honoured only when idle |
| opndA | input | P | Unsigned multiplicand |
| opndB | input | P | Unsigned multiplier |
| product | output | 2P | Result register, built one bit per column |
| done | output | 1 | One-cycle pulse after the last column is committed |

## Verification
The checker assumes that the operands matter only on the cycle where `start` is accepted. It also assumes that a `start` arriving during a run is simply discarded, so it checks that the captured operands stay stable in that case instead of asking the driver never to do it. The stimulus drives operands only together with `start` and changes them freely while the block is idle or busy. This tests that nothing other than the accepted start reaches the captured values. One run raises `start` in the middle of a sweep with different operands, and all-ones operands drive the longest carry chains up to the top column, where dropped carries must be zero.

// File: rtl/colcount_pkg.sv
package colcount_pkg;

  typedef struct packed {
    logic load;    // capture operands, clear state
    logic step;    // scan one element
    logic commit;  // this element closes the column
  } ctrlStrobe_t;

  // first multiplicand index of the AND terms in column r
  function automatic int andLo(int r, int p);
    return (r < p) ? 0 : r - p + 1;
  endfunction

  // number of AND terms in column r
  function automatic int andCnt(int r, int p);
    return (r < p) ? r + 1 : 2 * p - 1 - r;
  endfunction

  // number of carry slots reserved in column r
  function automatic int carCnt(int r, int cw);
    return (r < cw) ? r : cw;
  endfunction

endpackage

// File: rtl/colcount_ctrl.sv
module colcount_ctrl
  import colcount_pkg::*;
#(
  parameter int P = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output ctrlStrobe_t        strobe,
  output logic [$clog2(2*P)-1:0]             col,
  output logic [$clog2(P+$clog2(P)+1)-1:0]   elem,
  output logic               busy,
  output logic               done
);
  localparam int NCOL = 2 * P;
  localparam int CW   = $clog2(P);
  localparam int CIW  = $clog2(NCOL);
  localparam int EW   = $clog2(P + CW + 1);

  typedef enum logic {IDLE, RUN} state_t;
  state_t state;

  logic lastElem;
  logic lastCol;

  always_comb begin
    lastElem = (int'(elem) ==
                andCnt(int'(col), P) + carCnt(int'(col), CW) - 1);
    lastCol  = (int'(col) == NCOL - 1);
    strobe.load   = (state == IDLE) && start;
    strobe.step   = (state == RUN);
    strobe.commit = (state == RUN) && lastElem;
  end

  assign busy = (state == RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      col   <= '0;
      elem  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: begin
          if (start) begin
            state <= RUN;
            col   <= '0;
            elem  <= '0;
          end
        end
        RUN: begin
          if (lastElem) begin
            elem <= '0;
            if (lastCol) begin
              state <= IDLE;
              done  <= 1'b1;
            end else begin
              col <= col + CIW'(1);
            end
          end else begin
            elem <= elem + EW'(1);
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/colcount_dp.sv
module colcount_dp
  import colcount_pkg::*;
#(
  parameter int P = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [$clog2(2*P)-1:0]           col,
  input  logic [$clog2(P+$clog2(P)+1)-1:0] elem,
  input  logic [P-1:0]         inA,
  input  logic [P-1:0]         inB,
  output logic [2*P-1:0]       product,
  output logic [P-1:0]         opA,
  output logic [P-1:0]         opB,
  output logic [$clog2(P):0]   count,
  output logic                 lostCarry
);
  localparam int NCOL = 2 * P;
  localparam int CW   = $clog2(P);
  localparam int CNTW = CW + 1;
  localparam int IW   = (P > 1) ? $clog2(P) : 1;

  logic [CW-1:0]   carryMem [NCOL];
  logic            elemBit;
  logic [CNTW-1:0] total;

  always_comb begin
    int r, lo, nA, e, jI, bI, slot;
    r    = int'(col);
    lo   = andLo(r, P);
    nA   = andCnt(r, P);
    e    = int'(elem);
    jI   = 0;
    bI   = 0;
    slot = 0;
    elemBit = 1'b0;
    if (e < nA) begin
      jI = lo + e;
      bI = r - jI;
      elemBit = opA[IW'(jI)] & opB[IW'(bI)];
    end else begin
      slot = e - nA;
      for (int s = 0; s < CW; s++)
        if (s == slot) elemBit = carryMem[col][s];
    end
    total = count + CNTW'(elemBit);
    lostCarry = 1'b0;
    for (int k = 1; k <= CW; k++)
      if (r + k >= NCOL) lostCarry = lostCarry | total[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA     <= '0;
      opB     <= '0;
      count   <= '0;
      product <= '0;
      for (int c = 0; c < NCOL; c++) carryMem[c] <= '0;
    end else if (strobe.load) begin
      opA     <= inA;
      opB     <= inB;
      count   <= '0;
      product <= '0;
      for (int c = 0; c < NCOL; c++) carryMem[c] <= '0;
    end else if (strobe.step) begin
      if (strobe.commit) begin
        count        <= '0;
        product[col] <= total[0];
        for (int c = 0; c < NCOL; c++)
          for (int k = 1; k <= CW; k++)
            if (c == int'(col) + k) carryMem[c][k-1] <= total[k];
      end else begin
        count <= total;
      end
    end
  end

endmodule

// File: rtl/colcount_mult.sv
module colcount_mult
  import colcount_pkg::*;
#(
  parameter int P = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [P-1:0]   opndA,
  input  logic [P-1:0]   opndB,
  output logic [2*P-1:0] product,
  output logic           done
);
  localparam int CW   = $clog2(P);
  localparam int CIW  = $clog2(2 * P);
  localparam int EW   = $clog2(P + CW + 1);

  ctrlStrobe_t    strobe;
  logic [CIW-1:0] col;
  logic [EW-1:0]  elem;
  logic           busy;
  logic [P-1:0]   opA;
  logic [P-1:0]   opB;
  logic [CW:0]    count;
  logic           lostCarry;

  colcount_ctrl #(.P(P)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe),
    .col(col), .elem(elem), .busy(busy), .done(done)
  );

  colcount_dp #(.P(P)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .col(col), .elem(elem),
    .inA(opndA), .inB(opndB), .product(product), .opA(opA), .opB(opB),
    .count(count), .lostCarry(lostCarry)
  );

endmodule

// File: rtl/colcount_chk.sv
module colcount_chk #(
  parameter int P = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 done,
  input logic                 busy,
  input logic                 commit,
  input logic [2*P-1:0]       product,
  input logic [P-1:0]         opA,
  input logic [P-1:0]         opB,
  input logic [$clog2(2*P)-1:0]           col,
  input logic [$clog2(P+$clog2(P)+1)-1:0] elem,
  input logic [$clog2(P):0]   count,
  input logic                 lostCarry
);
  localparam int NCOL = 2 * P;

  AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == (2*P)'(opA) * (2*P)'(opB))); // R2

  AST_COL_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (commit && int'(col) != NCOL - 1) |=> (int'(col) == int'($past(col)) + 1)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(count) <= int'(elem))); // R3

  AST_NO_LOST_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !lostCarry); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(opA) && $stable(opB))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product)); // R8

endmodule

bind colcount_mult colcount_chk #(.P(P)) chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .busy(busy),
  .commit(strobe.commit), .product(product), .opA(opA), .opB(opB),
  .col(col), .elem(elem), .count(count), .lostCarry(lostCarry)
);

// File: tb/colcount_mult_test.sv
module colcount_mult_test;
  localparam int P = 8;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [P-1:0]   opndA = '0;
  logic [P-1:0]   opndB = '0;
  logic [2*P-1:0] product;
  logic           done;

  int checks = 0;
  int fails  = 0;
  int expLat = 0;

  colcount_mult #(.P(P)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opndA(opndA),
    .opndB(opndB), .product(product), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [P-1:0] x, input logic [P-1:0] y,
                       input bit inject, output int lat);
    @(negedge clk);
    opndA = x; opndB = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opndA = ~x; opndB = y ^ 8'h5a;
    lat = 0;
    while (lat < 1000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (start) start = 1'b0;
      if (inject && lat == 5) begin
        start = 1'b1; opndA = 8'hff; opndB = 8'h01;
      end
      if (done) break;
    end
  endtask

  task automatic testOp(input logic [P-1:0] x, input logic [P-1:0] y,
                        input string tag);
    int lat;
    runOp(x, y, 1'b0, lat);
    if (lat >= 1000) begin
      check({tag, " watchdog"}, lat, expLat);
      return;
    end
    check(tag, product, longint'(x) * longint'(y));
    check("R6 latency", lat, expLat);
    @(negedge clk);
    check("R6 done width", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [2*P-1:0] held;
    for (int r = 0; r < 2*P; r++) begin
      expLat += ((r < P) ? r + 1 : 2*P - 1 - r);
      expLat += ((r < $clog2(P)) ? r : $clog2(P));
    end

    repeat (3) @(negedge clk);
    check("R1 product in reset", product, 0);
    check("R1 done in reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 product after reset", product, 0);
    check("R1 done after reset", done, 0);

    // R2 R3 R4: exhaustive 4-bit operands
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        testOp(P'(a), P'(b), "R2 R4 nibble sweep");

    // R5: widest carries, plus extremes
    testOp('1, '1, "R5 all ones");
    testOp('0, '1, "R3 zero operand");
    testOp('1, '0, "R3 zero operand");
    testOp('1, 8'h01, "R4 single column");

    // R2: random full-width operands
    for (int n = 0; n < 200; n++)
      testOp(P'($urandom), P'($urandom), "R2 random");

    // R7: start during a run is ignored
    runOp(8'hd3, 8'hb7, 1'b1, lat);
    check("R7 product", product, 16'(8'hd3) * 16'(8'hb7));
    check("R7 latency", lat, expLat);

    // R8: idle operand activity leaves result alone
    @(negedge clk);
    held = product;
    for (int i = 0; i < 20; i++) begin
      opndA = P'($urandom); opndB = P'($urandom);
      @(negedge clk);
      check("R8 done idle", done, 0);
    end
    check("R8 product held", product, held);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule